// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit unsigned count that advances once per qualified counter tick. Software controls it through a 32-bit APB register frame: it can start and stop the count, load either half of it, make it freeze while a debug halt is requested, and switch from unit steps to scaled steps. In scaled mode every tick adds an unsigned fixed-point increment with 8 integer bits (word bits [31:24]) and 24 fraction bits (bits [23:0]). The increment comes from one of two scale registers, chosen by the clock-source code that the surrounding clock logic reports. A 24-bit fraction accumulator sits beside the count, so fractional increments are not lost.

The frame belongs to one security domain, set by a parameter. An access from the other domain, or to an address the frame does not decode, changes nothing, reads as zero and latches an error-pending flag. The interrupt output is that flag gated by an enable. Optionally the bus error response is raised, but only for the security mismatch. The count is also driven out in parallel for the timer frames that consume it.

Register word offsets (byte address): CONTROL 0x00, STATUS 0x04, COUNT_LO 0x08, COUNT_HI 0x0C, SCALE_A 0x10, SCALE_B 0x14. Any other address inside the frame, and any address with bits [1:0] non-zero, is undecoded. CONTROL bits: 0 count enable, 1 halt-on-debug enable, 2 scaling enable, 3 interrupt enable, 4 bus-error enable.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset the count is 0, CONTROL reads 0, `irq_o` is 0, and both scale registers read 0x0100_0000 (1.0).
- R2: With CONTROL bit 0 set and bit 2 clear, every cycle with `tick_i` high adds exactly 1 to the count. With bit 0 clear or `tick_i` low the count holds.
- R3: With CONTROL bits 0 and 2 set, each tick adds the selected 8.24 value to the {count, fraction} pair. The fraction carry goes into the count together with the integer part.
- R4: `clk_src_i` value 1 selects SCALE_A and value 2 selects SCALE_B. With values 0 or 3 a scaled tick does not move the count. STATUS bits [3:2] report `clk_src_i`.
- R5: While CONTROL bit 1 is set and `dbg_halt_i` is high, ticks do not move the count and STATUS bit 0 reads 1. With bit 1 clear, `dbg_halt_i` has no effect.
- R6: A write to COUNT_LO or COUNT_HI replaces that half of the count and clears the fraction accumulator. A carry from the low half reaches the high half.
- R7: When `scale_wr_any_i` is 0, writes to SCALE_A/SCALE_B are dropped while CONTROL bit 0 is set. When it is 1, they are always accepted. STATUS bit 4 reports `scale_wr_any_i`.
- R8: An access whose `acc_nonsec_i` differs from the frame domain changes no register and reads 0. It sets the pending flag, and `pslverr` is high during it exactly when CONTROL bit 4 is set.
- R9: An access to an undecoded address changes no register and reads 0. It sets the pending flag and never raises `pslverr`.
- R10: STATUS bit 1 is the pending flag and `irq_o` is pending AND CONTROL bit 3. Writing STATUS with bit 1 set clears the flag.
- R11: A count write in the same cycle as a tick takes the written value and drops the tick. An error in the same cycle as a clear attempt leaves the flag set.
- R12: CONTROL bits [4:0] and both scale registers read back the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the frame |
| pwdata | input | 32 | APB write data |
| acc_nonsec_i | input | 1 | Access security attribute, 1 = non-secure |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response |
| tick_i | input | 1 | Counter tick qualifier |
| dbg_halt_i | input | 1 | Debug halt request |
| clk_src_i | input | 2 | Active clock-source code |
| scale_wr_any_i | input | 1 | Allows scale writes while counting |
| count_o | output | 64 | Current count |
| irq_o | output | 1 | Error interrupt |

## Verification
Two pairs of functions can land in one clock edge. A count load can meet a counter tick, and a new error can meet a software clear of the pending flag. The first is provoked by holding `tick_i` high through a whole COUNT_LO write. It is judged by the count equalling the written value exactly, with no extra step. The second is provoked by a STATUS clear write issued from the wrong security domain while the flag is set. It is judged by `irq_o` staying high afterwards.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 6;

    // Word indices of the register frame
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CLO  = 2;
    localparam int REG_CHI  = 3;
    localparam int REG_SCA  = 4;
    localparam int REG_SCB  = 5;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic slverr_en;
        logic irq_en;
        logic scale_en;
        logic halt_en;
        logic cnt_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_BAD_LO = 2'd0,
        SRC_A      = 2'd1,
        SRC_B      = 2'd2,
        SRC_BAD_HI = 2'd3
    } clk_src_e;

endpackage

// File: rtl/ssc_apb_decode.sv
module ssc_apb_decode #(
    parameter int   ADDR_W   = 12,
    parameter int   NUM_REGS = 6,
    parameter logic FRAME_NS = 1'b0
) (
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic                acc_nonsec,
    output logic                sec_err,
    output logic                dec_err,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic             access;
    logic             dom_ok;
    logic             aligned;
    logic             known;
    logic [IDX_W-1:0] idx;

    assign access  = psel & penable;
    assign dom_ok  = (acc_nonsec == FRAME_NS);
    assign aligned = (paddr[1:0] == 2'b00);
    assign idx     = paddr[ADDR_W-1:2];
    assign known   = aligned & (idx < IDX_W'(NUM_REGS));

    assign sec_err = access & ~dom_ok;
    assign dec_err = access & dom_ok & ~known;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        logic hit;
        assign hit       = access & dom_ok & aligned & (idx == IDX_W'(g));
        assign wr_sel[g] = hit & pwrite;
        assign rd_sel[g] = hit & ~pwrite;
    end

endmodule

// File: rtl/ssc_scale_bank.sv
module ssc_scale_bank #(
    parameter int             NUM_SRC = 2,
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = 32'h0100_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          wr_en,
    input  logic                        allow,
    input  logic [W-1:0]                wdata,
    output logic [NUM_SRC-1:0][W-1:0]   scale_o
);
    logic [NUM_SRC-1:0][W-1:0] scale_d;
    logic [NUM_SRC-1:0][W-1:0] scale_q;

    always_comb begin
        scale_d = scale_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_en[i] && allow) begin
                scale_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                scale_q[i] <= RST_VAL;
            end
        end else begin
            scale_q <= scale_d;
        end
    end

    assign scale_o = scale_q;

endmodule

// File: rtl/ssc_count_core.sv
module ssc_count_core #(
    parameter int CNT_W  = 64,
    parameter int DW     = 32,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step,
    input  logic                      scaled,
    input  logic [INT_W+FRAC_W-1:0]   inc,
    input  logic                      ld_lo,
    input  logic                      ld_hi,
    input  logic [DW-1:0]             wdata,
    output logic [CNT_W-1:0]          cnt_o
);
    localparam int INC_W = INT_W + FRAC_W;
    localparam int HI_W  = CNT_W - DW;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] frac;
    } core_t;

    core_t             st_d;
    core_t             st_q;
    logic [FRAC_W:0]   fsum;
    logic [CNT_W-1:0]  delta;

    always_comb begin
        st_d  = st_q;
        fsum  = {1'b0, st_q.frac} + {1'b0, inc[FRAC_W-1:0]};
        delta = CNT_W'(inc[INC_W-1:FRAC_W]) + CNT_W'(fsum[FRAC_W]);
        // a load wins over a tick in the same cycle
        if (ld_lo) begin
            st_d.cnt[DW-1:0] = wdata;
            st_d.frac        = '0;
        end else if (ld_hi) begin
            st_d.cnt[CNT_W-1:DW] = wdata[HI_W-1:0];
            st_d.frac            = '0;
        end else if (step) begin
            if (scaled) begin
                st_d.cnt  = st_q.cnt + delta;
                st_d.frac = fsum[FRAC_W-1:0];
            end else begin
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter
    import ssc_pkg::*;
#(
    parameter int                  ADDR_W    = 12,
    parameter int                  CNT_W     = 64,
    parameter int                  INT_W     = 8,
    parameter int                  FRAC_W    = 24,
    parameter logic                FRAME_NS  = 1'b0,
    parameter logic [DATA_W-1:0]   SCALE_RST = 32'h0100_0000
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    input  logic                acc_nonsec_i,
    output logic [DATA_W-1:0]   prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic                tick_i,
    input  logic                dbg_halt_i,
    input  logic [1:0]          clk_src_i,
    input  logic                scale_wr_any_i,
    output logic [CNT_W-1:0]    count_o,
    output logic                irq_o
);
    localparam int NUM_SRC = 2;
    localparam int INC_W   = INT_W + FRAC_W;
    localparam int HI_W    = CNT_W - DATA_W;

    typedef struct packed {
        ctrl_t ctrl;
        logic  pend;
    } top_t;

    top_t                              st_d;
    top_t                              st_q;
    logic                              sec_err_w;
    logic                              dec_err_w;
    logic [NUM_REGS-1:0]               wr_sel_w;
    logic [NUM_REGS-1:0]               rd_sel_w;
    logic                              stat_clr_w;
    logic                              cnt_ld_w;
    logic                              halted_w;
    logic                              src_ok_w;
    logic                              step_w;
    logic [INC_W-1:0]                  inc_w;
    logic [NUM_SRC-1:0][DATA_W-1:0]    scale_w;
    logic [DATA_W-1:0]                 rdata_w;

    ssc_apb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .FRAME_NS (FRAME_NS)
    ) u_dec (
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .acc_nonsec (acc_nonsec_i),
        .sec_err    (sec_err_w),
        .dec_err    (dec_err_w),
        .wr_sel     (wr_sel_w),
        .rd_sel     (rd_sel_w)
    );

    ssc_scale_bank #(
        .NUM_SRC (NUM_SRC),
        .W       (DATA_W),
        .RST_VAL (SCALE_RST)
    ) u_scale (
        .clk     (pclk),
        .rst_n   (presetn),
        .wr_en   ({wr_sel_w[REG_SCB], wr_sel_w[REG_SCA]}),
        .allow   (scale_wr_any_i | ~st_q.ctrl.cnt_en),
        .wdata   (pwdata),
        .scale_o (scale_w)
    );

    // clock-source selection of the increment
    always_comb begin
        src_ok_w = 1'b0;
        inc_w    = scale_w[0][INC_W-1:0];
        case (clk_src_i)
            SRC_A: begin
                src_ok_w = 1'b1;
                inc_w    = scale_w[0][INC_W-1:0];
            end
            SRC_B: begin
                src_ok_w = 1'b1;
                inc_w    = scale_w[1][INC_W-1:0];
            end
            default: begin
                src_ok_w = 1'b0;
            end
        endcase
    end

    assign halted_w   = st_q.ctrl.halt_en & dbg_halt_i;
    assign step_w     = tick_i & st_q.ctrl.cnt_en & ~halted_w
                        & (~st_q.ctrl.scale_en | src_ok_w);
    assign cnt_ld_w   = wr_sel_w[REG_CLO] | wr_sel_w[REG_CHI];
    assign stat_clr_w = wr_sel_w[REG_STAT] & pwdata[1];

    ssc_count_core #(
        .CNT_W  (CNT_W),
        .DW     (DATA_W),
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_core (
        .clk    (pclk),
        .rst_n  (presetn),
        .step   (step_w),
        .scaled (st_q.ctrl.scale_en),
        .inc    (inc_w),
        .ld_lo  (wr_sel_w[REG_CLO]),
        .ld_hi  (wr_sel_w[REG_CHI]),
        .wdata  (pwdata),
        .cnt_o  (count_o)
    );

    // control and pending flag next state
    always_comb begin
        st_d = st_q;
        if (wr_sel_w[REG_CTRL]) begin
            st_d.ctrl = ctrl_t'(pwdata[CTRL_W-1:0]);
        end
        // a new error wins over a clear
        if (sec_err_w || dec_err_w) begin
            st_d.pend = 1'b1;
        end else if (stat_clr_w) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read path: zero unless a decoded, domain-matched read
    always_comb begin
        rdata_w = '0;
        if (rd_sel_w[REG_CTRL]) begin
            rdata_w = DATA_W'(st_q.ctrl);
        end
        if (rd_sel_w[REG_STAT]) begin
            rdata_w = DATA_W'({scale_wr_any_i, clk_src_i, st_q.pend, halted_w});
        end
        if (rd_sel_w[REG_CLO]) begin
            rdata_w = count_o[DATA_W-1:0];
        end
        if (rd_sel_w[REG_CHI]) begin
            rdata_w = DATA_W'(count_o[CNT_W-1:CNT_W-HI_W]);
        end
        if (rd_sel_w[REG_SCA]) begin
            rdata_w = scale_w[0];
        end
        if (rd_sel_w[REG_SCB]) begin
            rdata_w = scale_w[1];
        end
    end

    assign prdata  = rdata_w;
    assign pready  = 1'b1;
    assign pslverr = sec_err_w & st_q.ctrl.slverr_en;
    assign irq_o   = st_q.pend & st_q.ctrl.irq_en;

endmodule

// File: rtl/ssc_check.sv
module ssc_check #(
    parameter int CNT_W = 64
) (
    input logic             pclk,
    input logic             presetn,
    input logic [CNT_W-1:0] count_o,
    input logic             pslverr,
    input logic             tick_i,
    input logic             dbg_halt_i,
    input logic             en,
    input logic             halt_en,
    input logic             scale_en,
    input logic             pend,
    input logic             sec_err,
    input logic             dec_err,
    input logic             cnt_ld,
    input logic             stat_clr
);

    // R2: no tick and no load keeps the count
    a_r2_idle_hold: assert property (@(posedge pclk) disable iff (!presetn)
        (!tick_i && !cnt_ld) |=> $stable(count_o));

    // R2: unit step in unscaled mode
    a_r2_unit_step: assert property (@(posedge pclk) disable iff (!presetn)
        (tick_i && en && !scale_en && !(halt_en && dbg_halt_i) && !cnt_ld)
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R3: one scaled step never exceeds 255 + carry
    a_r3_step_bound: assert property (@(posedge pclk) disable iff (!presetn)
        (tick_i && en && scale_en && !cnt_ld)
        |=> ((count_o - $past(count_o)) <= CNT_W'(256)));

    // R5: halt-on-debug freezes the count
    a_r5_halt_freeze: assert property (@(posedge pclk) disable iff (!presetn)
        (halt_en && dbg_halt_i && !cnt_ld) |=> $stable(count_o));

    // R8: security mismatch latches the pending flag
    a_r8_sec_pend: assert property (@(posedge pclk) disable iff (!presetn)
        sec_err |=> pend);

    // R9: decode errors never give a bus error response
    a_r9_dec_no_slverr: assert property (@(posedge pclk) disable iff (!presetn)
        dec_err |-> !pslverr);

    // R9: decode errors latch the pending flag
    a_r9_dec_pend: assert property (@(posedge pclk) disable iff (!presetn)
        dec_err |=> pend);

    // R10: a clear without a concurrent error empties the flag
    a_r10_clear: assert property (@(posedge pclk) disable iff (!presetn)
        (stat_clr && !sec_err && !dec_err) |=> !pend);

endmodule

bind scaled_sys_counter ssc_check #(.CNT_W(CNT_W)) u_chk (
    .pclk       (pclk),
    .presetn    (presetn),
    .count_o    (count_o),
    .pslverr    (pslverr),
    .tick_i     (tick_i),
    .dbg_halt_i (dbg_halt_i),
    .en         (st_q.ctrl.cnt_en),
    .halt_en    (st_q.ctrl.halt_en),
    .scale_en   (st_q.ctrl.scale_en),
    .pend       (st_q.pend),
    .sec_err    (sec_err_w),
    .dec_err    (dec_err_w),
    .cnt_ld     (cnt_ld_w),
    .stat_clr   (stat_clr_w)
);

// File: tb/scaled_sys_counter_test.sv
module scaled_sys_counter_test;

    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_STAT = 12'h004;
    localparam logic [11:0] A_CLO  = 12'h008;
    localparam logic [11:0] A_CHI  = 12'h00C;
    localparam logic [11:0] A_SCA  = 12'h010;
    localparam logic [11:0] A_SCB  = 12'h014;

    // {op(0=write,1=read-compare), addr, data, expected}
    localparam int NVEC = 14;
    localparam logic [77:0] VEC [NVEC] = '{
        {2'd0, A_CTRL, 32'h0000_0000, 32'h0},
        {2'd1, A_CTRL, 32'h0,         32'h0000_0000},
        {2'd0, A_CLO,  32'hDEAD_BEEF, 32'h0},
        {2'd1, A_CLO,  32'h0,         32'hDEAD_BEEF},
        {2'd0, A_CHI,  32'h1234_5678, 32'h0},
        {2'd1, A_CHI,  32'h0,         32'h1234_5678},
        {2'd0, A_SCA,  32'h0280_0000, 32'h0},
        {2'd1, A_SCA,  32'h0,         32'h0280_0000},
        {2'd0, A_SCB,  32'h0040_0000, 32'h0},
        {2'd1, A_SCB,  32'h0,         32'h0040_0000},
        {2'd1, A_STAT, 32'h0,         32'h0000_0004},
        {2'd0, A_CTRL, 32'h0000_001E, 32'h0},
        {2'd1, A_CTRL, 32'h0,         32'h0000_001E},
        {2'd0, A_CTRL, 32'h0000_0000, 32'h0}
    };

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        acc_nonsec_i = 1'b0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        tick_i = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic [1:0]  clk_src_i = 2'd1;
    logic        scale_wr_any_i = 1'b0;
    logic [63:0] count_o;
    logic        irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2.5 pclk = ~pclk;

    scaled_sys_counter uut (
        .pclk           (pclk),
        .presetn        (presetn),
        .psel           (psel),
        .penable        (penable),
        .pwrite         (pwrite),
        .paddr          (paddr),
        .pwdata         (pwdata),
        .acc_nonsec_i   (acc_nonsec_i),
        .prdata         (prdata),
        .pready         (pready),
        .pslverr        (pslverr),
        .tick_i         (tick_i),
        .dbg_halt_i     (dbg_halt_i),
        .clk_src_i      (clk_src_i),
        .scale_wr_any_i (scale_wr_any_i),
        .count_o        (count_o),
        .irq_o          (irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic ns, output logic [31:0] rd, output logic err);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; acc_nonsec_i = ns;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        rd  = prdata;
        err = pslverr;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; acc_nonsec_i = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r;
        logic e;
        apb(1'b1, a, d, 1'b0, r, e);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r);
        logic e;
        apb(1'b0, a, 32'h0, 1'b0, r, e);
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge pclk);
        tick_i = 1'b0;
    endtask

    task automatic load(input logic [63:0] v);
        wr(A_CLO, v[31:0]);
        wr(A_CHI, v[63:32]);
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        e;

        repeat (4) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1: reset state
        chk("R1 count", count_o, 64'h0);
        chk("R1 irq", {63'h0, irq_o}, 64'h0);
        rd(A_CTRL, r); chk("R1 ctrl", {32'h0, r}, 64'h0);
        rd(A_SCA, r);  chk("R1 scale A", {32'h0, r}, 64'h0100_0000);
        rd(A_SCB, r);  chk("R1 scale B", {32'h0, r}, 64'h0100_0000);

        // R12: table of register writes and read-backs
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][77:76] == 2'd0) begin
                wr(VEC[i][75:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][75:64], r);
                chk("R12 table", {32'h0, r}, {32'h0, VEC[i][31:0]});
            end
        end

        // R2: unit steps, idle hold, disabled hold
        load(64'h0);
        wr(A_CTRL, 32'h1);
        ticks(10);
        chk("R2 ten ticks", count_o, 64'd10);
        repeat (5) @(negedge pclk);
        chk("R2 idle hold", count_o, 64'd10);
        wr(A_CTRL, 32'h0);
        ticks(3);
        chk("R2 disabled hold", count_o, 64'd10);

        // R3/R4: scaled steps with source selection
        wr(A_SCA, 32'h0180_0000);
        wr(A_SCB, 32'h0040_0000);
        load(64'h0);
        clk_src_i = 2'd1;
        wr(A_CTRL, 32'h5);
        ticks(4);
        chk("R3 1.5 x4", count_o, 64'd6);
        ticks(3);
        chk("R3 fraction carry", count_o, 64'd10);
        clk_src_i = 2'd2;
        ticks(2);
        chk("R4 source B carry", count_o, 64'd11);
        clk_src_i = 2'd0;
        ticks(3);
        chk("R4 invalid 0 holds", count_o, 64'd11);
        clk_src_i = 2'd3;
        rd(A_STAT, r); chk("R4 status source", {32'h0, r}, 64'h0000_000C);
        ticks(3);
        chk("R4 invalid 3 holds", count_o, 64'd11);
        clk_src_i = 2'd1;

        // R7: scale write protection while counting
        wr(A_SCA, 32'h0500_0000);
        rd(A_SCA, r); chk("R7 protected", {32'h0, r}, 64'h0180_0000);
        scale_wr_any_i = 1'b1;
        wr(A_SCA, 32'h0500_0000);
        rd(A_SCA, r); chk("R7 override", {32'h0, r}, 64'h0500_0000);
        rd(A_STAT, r); chk("R7 status override", {32'h0, r}, 64'h0000_0014);
        scale_wr_any_i = 1'b0;

        // R5: halt on debug
        wr(A_CTRL, 32'h3);
        load(64'd100);
        dbg_halt_i = 1'b1;
        rd(A_STAT, r); chk("R5 halted bit", {32'h0, r}, 64'h0000_0005);
        ticks(5);
        chk("R5 frozen", count_o, 64'd100);
        dbg_halt_i = 1'b0;
        ticks(2);
        chk("R5 resumes", count_o, 64'd102);
        wr(A_CTRL, 32'h1);
        dbg_halt_i = 1'b1;
        ticks(2);
        chk("R5 halt disabled", count_o, 64'd104);
        dbg_halt_i = 1'b0;

        // R6: carry across halves, load clears fraction
        load(64'h0000_0000_FFFF_FFFF);
        ticks(1);
        chk("R6 half carry", count_o, 64'h0000_0001_0000_0000);
        wr(A_CTRL, 32'h0);
        wr(A_SCA, 32'h0180_0000);
        load(64'h0);
        wr(A_CTRL, 32'h5);
        ticks(1);
        chk("R6 one scaled tick", count_o, 64'd1);
        wr(A_CLO, 32'h0);
        ticks(1);
        chk("R6 fraction cleared", count_o, 64'd1);

        // R11: load collides with tick
        wr(A_CTRL, 32'h1);
        tick_i = 1'b1;
        wr(A_CLO, 32'd1000);
        tick_i = 1'b0;
        chk("R11 load wins", count_o, 64'd1000);

        // R8: security mismatch
        wr(A_CTRL, 32'h18);
        apb(1'b0, A_CLO, 32'h0, 1'b1, r, e);
        chk("R8 read zero", {32'h0, r}, 64'h0);
        chk("R8 slverr", {63'h0, e}, 64'h1);
        chk("R10 irq set", {63'h0, irq_o}, 64'h1);
        apb(1'b1, A_CTRL, 32'h1, 1'b1, r, e);
        rd(A_CTRL, r); chk("R8 ctrl unchanged", {32'h0, r}, 64'h18);
        // R11: mismatched clear attempt leaves flag set
        apb(1'b1, A_STAT, 32'h2, 1'b1, r, e);
        chk("R11 error beats clear", {63'h0, irq_o}, 64'h1);
        rd(A_STAT, r); chk("R10 pending bit", {32'h0, r}, 64'h0000_0006);
        wr(A_STAT, 32'h2);
        chk("R10 cleared", {63'h0, irq_o}, 64'h0);
        wr(A_CTRL, 32'h08);
        apb(1'b0, A_CLO, 32'h0, 1'b1, r, e);
        chk("R8 slverr disabled", {63'h0, e}, 64'h0);
        chk("R10 irq again", {63'h0, irq_o}, 64'h1);
        wr(A_CTRL, 32'h00);
        chk("R10 irq masked", {63'h0, irq_o}, 64'h0);
        wr(A_STAT, 32'h2);

        // R9: decode error
        wr(A_CTRL, 32'h18);
        apb(1'b0, 12'h020, 32'h0, 1'b0, r, e);
        chk("R9 read zero", {32'h0, r}, 64'h0);
        chk("R9 no slverr", {63'h0, e}, 64'h0);
        chk("R9 irq", {63'h0, irq_o}, 64'h1);
        apb(1'b1, 12'h009, 32'h55, 1'b0, r, e);
        chk("R9 unaligned write ignored", count_o, 64'd1000);
        wr(A_STAT, 32'h2);
        chk("R9 cleared", {63'h0, irq_o}, 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule